// File: doc/BRIEF.md
# Packed-BCD Adder-Subtractor

This block adds or subtracts two unsigned packed-BCD numbers, each made of `DIGITS` decimal digits (three by default). Every digit position runs a 4-bit binary addition of the two digits and the incoming decimal carry. When the raw sum leaves the 0..9 range, it is brought back into range by adding six. A decimal carry then passes to the next digit up.

Subtraction works in nines' complement. Each digit of the subtrahend is replaced by nine minus that digit. A carry out of the top digit is returned into the bottom digit. When no such carry appears, the difference is negative: the block complements it once more to give the magnitude and raises a negative flag.

All results are registered. They appear on the first rising clock edge after the operands are presented. A separate flag reports any operand digit that is not a legal decimal digit.

Top module: `bcd_addsub_unit`

## Requirements
- R1: With `sub_en` low, `result_o` holds (A + B) modulo 10^DIGITS in packed BCD. Digit i occupies bits 4i+3..4i, with digit 0 the least significant.
- R2: A digit whose binary sum is above 9, or whose 4-bit adder carries out, is corrected by adding 6 and passes a carry to the next digit. For example, 5 + 5 gives digit 0 and carry 1, and 9 + 9 gives digit 8 and carry 1.
- R3: With `sub_en` high and A >= B, `result_o` holds A - B and `neg_o` is low.
- R4: With `sub_en` high and A < B, `result_o` holds the magnitude B - A and `neg_o` is high.
- R5: With `sub_en` high and A equal to B, `result_o` is all zero digits and `neg_o` is low. A result of all nines never appears for this case.
- R6: In add mode, `carry_o` is high exactly when A + B >= 10^DIGITS, and the carry is not folded back into the result. `carry_o` is low in subtract mode, and `neg_o` is low in add mode.
- R7: `bad_o` is high when any 4-bit digit of A or B is greater than 9, and low otherwise. `result_o` is then still a fixed function of the inputs.
- R8: Outputs update on the first rising edge of `clk` after the inputs are applied. While `rst_n` is low at an edge, every output is cleared to zero.
- R9: With three digits, 786 minus 348 gives 0100 0011 1000 (438) with `neg_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| opnd_a | input | 4*DIGITS | Operand A, packed BCD |
| opnd_b | input | 4*DIGITS | Operand B, packed BCD |
| sub_en | input | 1 | 1 selects A - B, 0 selects A + B |
| result_o | output | 4*DIGITS | Sum, or magnitude of the difference, in packed BCD |
| neg_o | output | 1 | Difference is negative (subtract mode only) |
| carry_o | output | 1 | Decimal carry out of the top digit (add mode only) |
| bad_o | output | 1 | An operand digit is greater than 9 |

## Verification
Every result, including the flags, is due one rising edge after its operands are driven. The bench drives each operand pair on a falling edge and reads all outputs 1 ns after the next rising edge, so each check sees exactly that pair's registered result.

With three digits, the bench sweeps a strided grid of A and B values in both modes. It also covers every equal pair in subtract mode, the largest sum, and the named 786 - 348 case. Illegal digits are placed in each operand. Expected values come from integer arithmetic on the decimal values.

// File: rtl/bcd_addsub_pkg.sv
// Package: shared digit type and digit-level helper functions for the
// packed-BCD adder-subtractor. Assumes 4-bit digits throughout.
package bcd_addsub_pkg;

    localparam int DIGIT_W = 4;

    typedef logic [DIGIT_W-1:0] bcd_digit_t;

    localparam bcd_digit_t DIGIT_MAX = 4'd9;
    localparam bcd_digit_t DIGIT_FIX = 4'd6;

    // Nines' complement of one digit; wraps for illegal digits (deterministic).
    function automatic bcd_digit_t nines_of(input bcd_digit_t d);
        return DIGIT_MAX - d;
    endfunction

    // True when a 4-bit field is not a legal decimal digit.
    function automatic logic digit_illegal(input bcd_digit_t d);
        return d > DIGIT_MAX;
    endfunction

endpackage

// File: rtl/bcd_digit_stage.sv
// Module: one decimal digit slice. A 4-bit binary adder sums two digits and
// a carry; a plus-six correction restores a legal digit and raises the
// decimal carry. Assumes legal input digits for a legal result; illegal
// inputs still give a fixed value.
module bcd_digit_stage
    import bcd_addsub_pkg::*;
(
    input  bcd_digit_t dig_a,
    input  bcd_digit_t dig_b,
    input  logic       car_in,
    output bcd_digit_t dig_sum,
    output logic       car_out
);

    logic [DIGIT_W:0] raw;
    bcd_digit_t       part;
    logic             bin_carry;
    logic             fix_needed;

    // Binary add of the two digits and the incoming decimal carry.
    always_comb begin
        raw       = {1'b0, dig_a} + {1'b0, dig_b} + {{DIGIT_W{1'b0}}, car_in};
        part      = raw[DIGIT_W-1:0];
        bin_carry = raw[DIGIT_W];
    end

    // Correction decision: binary carry, or bit 3 set with bit 2 or bit 1.
    always_comb begin
        fix_needed = bin_carry | (part[3] & part[2]) | (part[3] & part[1]);
    end

    // Apply the plus-six fix and pass the decimal carry upward.
    always_comb begin
        dig_sum = fix_needed ? part + DIGIT_FIX : part;
        car_out = fix_needed;
    end

endmodule

// File: rtl/bcd_ripple_chain.sv
// Module: DIGITS digit slices in a ripple chain, least significant digit
// first. Assumes packed operands with digit i at bits 4i+3..4i.
module bcd_ripple_chain
    import bcd_addsub_pkg::*;
#(
    parameter int DIGITS = 3
) (
    input  logic [DIGITS*DIGIT_W-1:0] add_a,
    input  logic [DIGITS*DIGIT_W-1:0] add_b,
    input  logic                      chain_cin,
    output logic [DIGITS*DIGIT_W-1:0] chain_sum,
    output logic                      chain_cout
);

    logic [DIGITS:0] link;

    // Feed the chain's carry input into the lowest slice.
    always_comb begin
        link[0] = chain_cin;
    end

    for (genvar gi = 0; gi < DIGITS; gi++) begin : g_slice
        bcd_digit_stage u_stage (
            .dig_a   (add_a[gi*DIGIT_W +: DIGIT_W]),
            .dig_b   (add_b[gi*DIGIT_W +: DIGIT_W]),
            .car_in  (link[gi]),
            .dig_sum (chain_sum[gi*DIGIT_W +: DIGIT_W]),
            .car_out (link[gi+1])
        );
    end

    // Report the decimal carry out of the top slice.
    always_comb begin
        chain_cout = link[DIGITS];
    end

endmodule

// File: rtl/bcd_nines_comp.sv
// Module: digit-wise nines' complement of a packed-BCD word. Assumes 4-bit
// digits; illegal digits wrap modulo 16.
module bcd_nines_comp
    import bcd_addsub_pkg::*;
#(
    parameter int DIGITS = 3
) (
    input  logic [DIGITS*DIGIT_W-1:0] word_in,
    output logic [DIGITS*DIGIT_W-1:0] word_out
);

    for (genvar gi = 0; gi < DIGITS; gi++) begin : g_digit
        // Replace this digit by nine minus itself.
        always_comb begin
            word_out[gi*DIGIT_W +: DIGIT_W] = nines_of(word_in[gi*DIGIT_W +: DIGIT_W]);
        end
    end

endmodule

// File: rtl/bcd_digit_check.sv
// Module: flags a packed word holding any 4-bit field above nine.
module bcd_digit_check
    import bcd_addsub_pkg::*;
#(
    parameter int DIGITS = 3
) (
    input  logic [DIGITS*DIGIT_W-1:0] word_in,
    output logic                      any_bad
);

    logic [DIGITS-1:0] per_digit;

    for (genvar gi = 0; gi < DIGITS; gi++) begin : g_digit
        // Mark this digit when it is not a legal decimal digit.
        always_comb begin
            per_digit[gi] = digit_illegal(word_in[gi*DIGIT_W +: DIGIT_W]);
        end
    end

    // Combine the per-digit marks.
    always_comb begin
        any_bad = |per_digit;
    end

endmodule

// File: rtl/bcd_addsub_unit.sv
// Module: top of the packed-BCD adder-subtractor. The subtrahend is
// nines'-complemented in subtract mode. Two ripple chains run with carry-in
// 0 and 1 so that the end-around carry resolves without a loop. Negative
// differences are recomplemented. Outputs are registered, with a
// synchronous active-low reset. Assumes unsigned operands.
module bcd_addsub_unit
    import bcd_addsub_pkg::*;
#(
    parameter int DIGITS = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [DIGITS*DIGIT_W-1:0] opnd_a,
    input  logic [DIGITS*DIGIT_W-1:0] opnd_b,
    input  logic                      sub_en,
    output logic [DIGITS*DIGIT_W-1:0] result_o,
    output logic                      neg_o,
    output logic                      carry_o,
    output logic                      bad_o
);

    localparam int WORD_W = DIGITS * DIGIT_W;

    logic [WORD_W-1:0] b_comp;
    logic [WORD_W-1:0] b_used;
    logic [WORD_W-1:0] sum_c0;
    logic [WORD_W-1:0] sum_c1;
    logic [WORD_W-1:0] sum_c0_comp;
    logic              cout_c0;
    logic              cout_c1;
    logic              bad_a;
    logic              bad_b;
    logic [WORD_W-1:0] nxt_result;
    logic              nxt_neg;
    logic              nxt_carry;

    bcd_nines_comp #(.DIGITS(DIGITS)) u_comp_b (
        .word_in  (opnd_b),
        .word_out (b_comp)
    );

    // Choose the subtrahend's complement or B itself.
    always_comb begin
        b_used = sub_en ? b_comp : opnd_b;
    end

    bcd_ripple_chain #(.DIGITS(DIGITS)) u_chain_c0 (
        .add_a      (opnd_a),
        .add_b      (b_used),
        .chain_cin  (1'b0),
        .chain_sum  (sum_c0),
        .chain_cout (cout_c0)
    );

    bcd_ripple_chain #(.DIGITS(DIGITS)) u_chain_c1 (
        .add_a      (opnd_a),
        .add_b      (b_used),
        .chain_cin  (1'b1),
        .chain_sum  (sum_c1),
        .chain_cout (cout_c1)
    );

    bcd_nines_comp #(.DIGITS(DIGITS)) u_recomp (
        .word_in  (sum_c0),
        .word_out (sum_c0_comp)
    );

    bcd_digit_check #(.DIGITS(DIGITS)) u_chk_a (
        .word_in (opnd_a),
        .any_bad (bad_a)
    );

    bcd_digit_check #(.DIGITS(DIGITS)) u_chk_b (
        .word_in (opnd_b),
        .any_bad (bad_b)
    );

    // Select the result: sum in add mode; in subtract mode, the carry-in-1
    // sum when the end-around carry appears, else the recomplemented sum.
    always_comb begin
        if (!sub_en) begin
            nxt_result = sum_c0;
            nxt_neg    = 1'b0;
            nxt_carry  = cout_c0;
        end else if (cout_c1) begin
            nxt_result = sum_c1;
            nxt_neg    = 1'b0;
            nxt_carry  = 1'b0;
        end else begin
            nxt_result = sum_c0_comp;
            nxt_neg    = 1'b1;
            nxt_carry  = 1'b0;
        end
    end

    // Register all outputs; the synchronous reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            neg_o    <= 1'b0;
            carry_o  <= 1'b0;
            bad_o    <= 1'b0;
        end else begin
            result_o <= nxt_result;
            neg_o    <= nxt_neg;
            carry_o  <= nxt_carry;
            bad_o    <= bad_a | bad_b;
        end
    end

    AST_NEG_ONLY_SUB: assert property (@(posedge clk) disable iff (!rst_n)
        neg_o |-> $past(sub_en)); // R6

    AST_CARRY_ONLY_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        carry_o |-> !$past(sub_en)); // R6

    AST_NO_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        neg_o |-> (result_o != '0)); // R4

    AST_EQUAL_GIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_en && (opnd_a == opnd_b) && !bad_a) |=> (result_o == '0 && !neg_o)); // R5

    for (genvar gi = 0; gi < DIGITS; gi++) begin : g_rng
        AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            !bad_o |-> (result_o[gi*DIGIT_W +: DIGIT_W] <= DIGIT_MAX)); // R2
    end

endmodule

// File: tb/bcd_addsub_unit_test.sv
// Bench: strided sweep of the three-digit adder-subtractor in both modes,
// with the expected values computed from decimal arithmetic.
module bcd_addsub_unit_test;

    localparam int DIGITS = 3;
    localparam int W      = DIGITS * 4;
    localparam int MODV   = 1000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic         sub_en = 1'b0;
    logic [W-1:0] result_o;
    logic         neg_o;
    logic         carry_o;
    logic         bad_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    bcd_addsub_unit #(.DIGITS(DIGITS)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .sub_en   (sub_en),
        .result_o (result_o),
        .neg_o    (neg_o),
        .carry_o  (carry_o),
        .bad_o    (bad_o)
    );

    always #2 clk = ~clk;

    function automatic logic [W-1:0] to_bcd(input int v);
        logic [W-1:0] r;
        int t;
        r = '0;
        t = v;
        for (int i = 0; i < DIGITS; i++) begin
            r[i*4 +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one operand pair, then read the results one edge later.
    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic s);
        @(negedge clk);
        opnd_a = a;
        opnd_b = b;
        sub_en = s;
        @(posedge clk);
        #1;
    endtask

    task automatic run_pair(input int a, input int b, input logic s);
        int sum;
        logic [W-1:0] er;
        apply(to_bcd(a), to_bcd(b), s);
        if (!s) begin
            sum = a + b;
            er  = to_bcd(sum % MODV);
            check(result_o == er, "R1 sum", result_o, er);
            check(carry_o == (sum >= MODV), "R6 carry", carry_o, (sum >= MODV));
            check(!neg_o, "R6 neg in add", neg_o, 0);
        end else if (a >= b) begin
            er = to_bcd(a - b);
            check(result_o == er && !neg_o, "R3 diff", {neg_o, result_o}, {1'b0, er});
            check(!carry_o, "R6 carry in sub", carry_o, 0);
        end else begin
            er = to_bcd(b - a);
            check(result_o == er && neg_o, "R4 neg diff", {neg_o, result_o}, {1'b1, er});
        end
        check(!bad_o, "R7 legal digits", bad_o, 0);
    endtask

    initial begin
        // R8 reset state
        opnd_a = to_bcd(999);
        opnd_b = to_bcd(999);
        repeat (3) @(posedge clk);
        #1;
        check(result_o == '0 && !neg_o && !carry_o && !bad_o, "R8 reset",
              {bad_o, carry_o, neg_o, result_o}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R9 named case
        run_pair(786, 348, 1'b1);
        check(result_o == 12'h438 && !neg_o, "R9 786-348", result_o, 12'h438);

        // R2 single-digit corrections
        run_pair(5, 5, 1'b0);
        check(result_o == 12'h010, "R2 5+5", result_o, 12'h010);
        run_pair(9, 9, 1'b0);
        check(result_o == 12'h018, "R2 9+9", result_o, 12'h018);
        run_pair(999, 999, 1'b0);
        check(result_o == 12'h998 && carry_o, "R6 999+999", {carry_o, result_o}, 13'h1998);

        // R5 every equal pair in subtract mode
        for (int v = 0; v < MODV; v++) begin
            apply(to_bcd(v), to_bcd(v), 1'b1);
            check(result_o == '0 && !neg_o, "R5 equal", {neg_o, result_o}, 0);
        end

        // R1 R3 R4 strided sweep in both modes
        for (int a = 0; a < MODV; a += 7) begin
            for (int b = 0; b < MODV; b += 13) begin
                run_pair(a, b, 1'b0);
                run_pair(a, b, 1'b1);
            end
        end
        run_pair(0, 999, 1'b1);
        run_pair(999, 0, 1'b1);
        run_pair(1, 999, 1'b0);

        // R7 illegal digits in each position of each operand
        for (int d = 0; d < DIGITS; d++) begin
            logic [W-1:0] x;
            x = to_bcd(123);
            x[d*4 +: 4] = 4'hA + 4'(d);
            apply(x, to_bcd(456), 1'b0);
            check(bad_o, "R7 bad A", bad_o, 1);
            apply(to_bcd(456), x, 1'b1);
            check(bad_o, "R7 bad B", bad_o, 1);
        end
        apply(12'hFFF, 12'hFFF, 1'b1);
        check(bad_o, "R7 all F", bad_o, 1);
        apply(to_bcd(900), to_bcd(99), 1'b0);
        check(!bad_o && result_o == 12'h999, "R7 flag clears", {bad_o, result_o}, 13'h0999);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule